// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block drives the active-low peripheral select lines of an SPI master over a stream of back-to-back transfers. Software loads a one-word transmit holding register; each load carries a peripheral index that picks which select line goes low. The sequencer moves the holding register into the shifter and pulses a start strobe. It then waits for the shifter's done pulse and decides whether the active select is released before the next transfer.

Two programmable idle windows shape the bus timing. A between-transfer window always separates the end of one transfer from the start of the next, even when the select stays low. A deselect window always separates the release of one select from the assertion of the next. A keep-asserted control holds the select low after a transfer while no new data arrives. A select is only forced high when pending data targets another peripheral, or when the keep control is cleared. Both windows are counted in clock cycles, and a programmed count of zero behaves as one cycle. The serial shifter and the bit clock are outside this block; the done input stands in for them.

Top module: `spi_cs_sequencer`

## Requirements
- R1: In the first cycle after reset, all select lines are high, `tx_empty` is 1 and `xfer_start` is 0.
- R2: `xfer_start` is a pulse in the cycle the select is asserted or kept. In that cycle and until `xfer_done`, exactly one select line is low and the select does not change. The low line is `cs_n[i]`, where i is the `tx_idx` value of the write that is loaded.
- R3: `tx_empty` is 0 in the cycle after a `tx_wr` pulse. It is 1 in the cycle `xfer_start` is high, unless a write was sampled at the edge that raised the strobe.
- R4: With `keep_sel` = 0 and no pending data when the between-transfer window ends, the select goes high exactly `max(gap_xfer,1)+1` cycles after the `xfer_done` cycle, and it stays low before then.
- R5: With `keep_sel` = 1 and no pending data, the select stays low after the transfer for as long as no write arrives.
- R6: When pending data targets the peripheral whose select is low, the next transfer starts without the select going high, in either `keep_sel` setting.
- R7: When pending data targets a different peripheral, the old select goes high before the new one goes low. Two select lines are never low at once, and the low line never moves straight to another line.
- R8: Between a `xfer_done` cycle and the next `xfer_start` cycle there are at least `max(gap_xfer,1)` cycles. When the select is kept and the data is already waiting, there are exactly that many.
- R9: Between releasing one select and asserting the next, all lines stay high for at least `max(gap_cs,1)` cycles. When data is already waiting, they stay high for exactly that many.
- R10: `xfer_start` is never high in two consecutive cycles. It is never high while a transfer is in flight, meaning after a start and before its `xfer_done`.
- R11: While the select is held low with no data, clearing `keep_sel` raises the select in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | One-cycle write strobe into the holding register |
| tx_idx | input | IDX_W (2) | Peripheral index written with the data |
| tx_empty | output | 1 | Holding register empty flag |
| keep_sel | input | 1 | Keep the select low after a transfer when no data waits |
| gap_xfer | input | DLY_W (8) | Between-transfer idle cycles (0 acts as 1) |
| gap_cs | input | DLY_W (8) | Deselect-to-select idle cycles (0 acts as 1) |
| xfer_done | input | 1 | Pulse from the shifter at the end of a transfer |
| xfer_start | output | 1 | One-cycle strobe that launches the shifter |
| cs_n | output | NUM_CS (4) | Active-low peripheral select lines |

## Verification
On every cycle, the assertions check that at most one select is low and that the low line never jumps straight to another line. They also check that the select is steady for the whole transfer, that the start strobe is a single pulse outside any transfer, and that the empty flag follows writes and loads. Lower bounds on both idle windows and the hold of a kept select are checked every cycle as well. The exact window lengths can only be shown by the directed scenarios: back-to-back same-peripheral writes, a change of peripheral, zero and long counts, and both keep settings. So can the release timing with the keep control cleared, and the release out of the held state when `keep_sel` drops.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // all selects high, nothing in flight
    ST_BUSY  = 3'd1,  // shifter running
    ST_GAP   = 3'd2,  // between-transfer idle window, select still low
    ST_HOLD  = 3'd3,  // select kept low, waiting for data
    ST_DESEL = 3'd4   // selects high, deselect idle window
  } seq_state_t;

endpackage

// File: rtl/cs_hold_reg.sv
module cs_hold_reg #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             take,
  output logic             empty,
  output logic [IDX_W-1:0] idx
);

  logic             empty_q;
  logic [IDX_W-1:0] idx_q;

  // A write in the same cycle as a load refills the register.
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      idx_q   <= '0;
    end else begin
      if (wr) begin
        empty_q <= 1'b0;
        idx_q   <= wr_idx;
      end else if (take) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign empty = empty_q;
  assign idx   = idx_q;

endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;

  // Loaded value of zero is promoted to one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? ONE : load_val;
    end else if (cnt_q > ONE) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expired = (cnt_q <= ONE);

endmodule

// File: rtl/cs_line_drive.sv
module cs_line_drive #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              rel,
  output logic [NUM_CS-1:0] cs_n
);

  logic [NUM_CS-1:0] cs_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        cs_q[i] <= 1'b1;
      end else if (sel) begin
        cs_q[i] <= (sel_idx != IDX_W'(i));
      end else if (rel) begin
        cs_q[i] <= 1'b1;
      end
    end
  end

  assign cs_n = cs_q;

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_pkg::*;
#(
  parameter  int NUM_CS = 4,
  parameter  int DLY_W  = 8,
  localparam int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic [IDX_W-1:0]  tx_idx,
  output logic              tx_empty,
  input  logic              keep_sel,
  input  logic [DLY_W-1:0]  gap_xfer,
  input  logic [DLY_W-1:0]  gap_cs,
  input  logic              xfer_done,
  output logic              xfer_start,
  output logic [NUM_CS-1:0] cs_n
);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] cur_q;
  logic             start_q;

  logic             hold_empty;
  logic [IDX_W-1:0] hold_idx;
  logic             hold_vld;
  logic             same_tgt;

  logic             take, start_d, sel, rel, tload, t_exp;
  logic [DLY_W-1:0] tval;

  cs_hold_reg #(.IDX_W(IDX_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .wr     (tx_wr),
    .wr_idx (tx_idx),
    .take   (take),
    .empty  (hold_empty),
    .idx    (hold_idx)
  );

  cs_gap_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tload),
    .load_val (tval),
    .expired  (t_exp)
  );

  cs_line_drive #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_lines (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .sel_idx (hold_idx),
    .rel     (rel),
    .cs_n    (cs_n)
  );

  assign hold_vld = ~hold_empty;
  assign same_tgt = (hold_idx == cur_q);

  always_comb begin
    take    = 1'b0;
    start_d = 1'b0;
    sel     = 1'b0;
    rel     = 1'b0;
    tload   = 1'b0;
    tval    = gap_xfer;
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (hold_vld) begin
          sel     = 1'b1;
          take    = 1'b1;
          start_d = 1'b1;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (xfer_done) begin
          tload   = 1'b1;
          tval    = gap_xfer;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (t_exp) begin
          if (hold_vld && same_tgt) begin
            take    = 1'b1;
            start_d = 1'b1;
            state_d = ST_BUSY;
          end else if (hold_vld || !keep_sel) begin
            rel     = 1'b1;
            tload   = 1'b1;
            tval    = gap_cs;
            state_d = ST_DESEL;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (hold_vld && same_tgt) begin
          take    = 1'b1;
          start_d = 1'b1;
          state_d = ST_BUSY;
        end else if (hold_vld || !keep_sel) begin
          rel     = 1'b1;
          tload   = 1'b1;
          tval    = gap_cs;
          state_d = ST_DESEL;
        end
      end
      ST_DESEL: begin
        if (t_exp) begin
          if (hold_vld) begin
            sel     = 1'b1;
            take    = 1'b1;
            start_d = 1'b1;
            state_d = ST_BUSY;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      if (sel) cur_q <= hold_idx;
    end
  end

  assign xfer_start = start_q;
  assign tx_empty   = hold_empty;

endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk #(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_wr,
  input logic              tx_empty,
  input logic              keep_sel,
  input logic [DLY_W-1:0]  gap_xfer,
  input logic [DLY_W-1:0]  gap_cs,
  input logic              xfer_done,
  input logic              xfer_start,
  input logic [NUM_CS-1:0] cs_n
);

  localparam logic [DLY_W:0] SAT = '1;
  localparam logic [DLY_W:0] ONE = (DLY_W+1)'(1);

  logic           in_flight, seen_done, seen_low;
  logic [DLY_W:0] since_done, hi_run, gmin_x, gmin_c;

  always_comb begin
    gmin_x = (gap_xfer == '0) ? ONE : {1'b0, gap_xfer};
    gmin_c = (gap_cs   == '0) ? ONE : {1'b0, gap_cs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_flight  <= 1'b0;
      seen_done  <= 1'b0;
      seen_low   <= 1'b0;
      since_done <= '0;
      hi_run     <= '0;
    end else begin
      if (xfer_start)     in_flight <= 1'b1;
      else if (xfer_done) in_flight <= 1'b0;
      if (xfer_done) begin
        seen_done  <= 1'b1;
        since_done <= '0;
      end else if (since_done != SAT) begin
        since_done <= since_done + ONE;
      end
      if (cs_n != '1) begin
        seen_low <= 1'b1;
        hi_run   <= '0;
      end else if (hi_run != SAT) begin
        hi_run <= hi_run + ONE;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n == '1 && tx_empty && !xfer_start));

  // R2
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> ($countones(~cs_n) == 1));

  // R2
  steady_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> ($stable(cs_n) && $countones(~cs_n) == 1));

  // R3
  empty_fall_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_empty);

  // R3
  empty_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && !$past(tx_wr)) |-> tx_empty);

  // R5
  kept_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(keep_sel) && $past(tx_empty) && $past(cs_n) != '1) |-> (cs_n == $past(cs_n)));

  // R7
  one_low_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  // R7
  no_direct_switch_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) != '1 && cs_n != '1) |-> (cs_n == $past(cs_n)));

  // R8
  xfer_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && seen_done) |-> (since_done >= gmin_x));

  // R9
  desel_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) == '1 && cs_n != '1 && seen_low) |-> (hi_run >= gmin_c));

  // R10
  single_start_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  // R10
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> !xfer_start);

endmodule

bind spi_cs_sequencer spi_cs_seq_chk #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_wr      (tx_wr),
  .tx_empty   (tx_empty),
  .keep_sel   (keep_sel),
  .gap_xfer   (gap_xfer),
  .gap_cs     (gap_cs),
  .xfer_done  (xfer_done),
  .xfer_start (xfer_start),
  .cs_n       (cs_n)
);

// File: tb/tb_spi_cs_sequencer.sv
module tb_spi_cs_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_wr = 1'b0;
  logic [1:0] tx_idx = '0;
  logic       keep_sel = 1'b0;
  logic [7:0] gap_xfer = 8'd1;
  logic [7:0] gap_cs = 8'd1;
  logic       xfer_done = 1'b0;
  logic       tx_empty, xfer_start;
  logic [3:0] cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // monitor records, one set per observed start
  int         s_cnt = 0, d_cnt = 0, s_gap = -1, s_hirun = 0;
  logic [3:0] s_cs = '1;
  logic       s_hi = 1'b0, s_empty = 1'b0;
  int         hi_run = 0, done_cyc = 0, busy = 0;
  logic       hi_seen = 1'b0, done_seen = 1'b0;

  spi_cs_sequencer dut (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_idx(tx_idx), .tx_empty(tx_empty),
    .keep_sel(keep_sel), .gap_xfer(gap_xfer), .gap_cs(gap_cs),
    .xfer_done(xfer_done), .xfer_start(xfer_start), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // shifter stand-in and waveform monitor
  initial begin : shifter_mon
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (rst) begin
        busy = 0; hi_run = 0; hi_seen = 1'b0; done_seen = 1'b0;
      end else begin
        if (cs_n == 4'hF) begin hi_run++; hi_seen = 1'b1; end
        if (xfer_start) begin
          s_cnt++;
          s_cs = cs_n; s_empty = tx_empty; s_hi = hi_seen; s_hirun = hi_run;
          s_gap = done_seen ? (cyc - done_cyc) : -1;
          hi_seen = 1'b0;
          busy = LAT;
        end else if (busy > 0) begin
          busy--;
          if (busy == 0) begin
            xfer_done = 1'b1; done_cyc = cyc; done_seen = 1'b1; d_cnt++;
          end
        end
        if (cs_n != 4'hF) hi_run = 0;
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_dut(input int gx, input int gc, input logic keep);
    rst = 1'b1; gap_xfer = 8'(gx); gap_cs = 8'(gc); keep_sel = keep;
    repeat (2) step();
    rst = 1'b0;
    step();
    check(cs_n == 4'hF, "R1 selects high", int'(cs_n), 15);
    check(tx_empty == 1'b1, "R1 empty after reset", int'(tx_empty), 1);
    check(xfer_start == 1'b0, "R1 no start after reset", int'(xfer_start), 0);
  endtask

  task automatic write(input int idx);
    tx_wr = 1'b1; tx_idx = 2'(idx);
    step();
    tx_wr = 1'b0;
    check(tx_empty == 1'b0, "R3 empty falls after write", int'(tx_empty), 0);
  endtask

  task automatic wait_start(input int n);
    for (int k = 0; k < 300 && s_cnt < n; k++) step();
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 300 && d_cnt < n; k++) step();
  endtask

  // keep clear, same peripheral back to back, then release
  task automatic t_same_nokeep();
    int sb, db;
    reset_dut(3, 2, 1'b0);
    sb = s_cnt; db = d_cnt;
    write(1);
    wait_start(sb + 1);
    check(s_cs == 4'b1101, "R2 select index 1", int'(s_cs), 13);
    check(s_empty == 1'b1, "R3 empty at load", int'(s_empty), 1);
    write(1);
    wait_start(sb + 2);
    check(s_hi == 1'b0, "R6 no deselect same target", int'(s_hi), 0);
    check(s_gap == 4, "R8 gap of 3", s_gap, 4);
    step();
    check(xfer_start == 1'b0, "R10 start is one cycle", int'(xfer_start), 0);
    wait_done(db + 2);
    repeat (3) step();
    check(cs_n == 4'b1101, "R4 low through gap", int'(cs_n), 13);
    step();
    check(cs_n == 4'hF, "R4 released after gap", int'(cs_n), 15);
  endtask

  // keep clear, change of peripheral
  task automatic t_change_nokeep();
    int sb;
    reset_dut(2, 3, 1'b0);
    sb = s_cnt;
    write(0);
    wait_start(sb + 1);
    check(s_cs == 4'b1110, "R2 select index 0", int'(s_cs), 14);
    write(2);
    wait_start(sb + 2);
    check(s_cs == 4'b1011, "R7 new select index 2", int'(s_cs), 11);
    check(s_hi == 1'b1, "R7 high between selects", int'(s_hi), 1);
    check(s_hirun == 3, "R9 deselect gap of 3", s_hirun, 3);
  endtask

  // keep set: hold, same target, new target, then drop keep
  task automatic t_keep();
    int sb, db;
    reset_dut(1, 4, 1'b1);
    sb = s_cnt; db = d_cnt;
    write(3);
    wait_start(sb + 1);
    wait_done(db + 1);
    repeat (20) step();
    check(cs_n == 4'b0111, "R5 select held without data", int'(cs_n), 7);
    check(tx_empty == 1'b1, "R3 empty while held", int'(tx_empty), 1);
    write(3);
    wait_start(sb + 2);
    check(s_hi == 1'b0, "R6 held select continues", int'(s_hi), 0);
    check(s_cs == 4'b0111, "R2 select index 3", int'(s_cs), 7);
    wait_done(db + 2);
    repeat (10) step();
    write(1);
    wait_start(sb + 3);
    check(s_cs == 4'b1101, "R7 switch from held select", int'(s_cs), 13);
    check(s_hi == 1'b1, "R7 high before switch", int'(s_hi), 1);
    check(s_hirun == 4, "R9 deselect gap of 4", s_hirun, 4);
    wait_done(db + 3);
    repeat (10) step();
    check(cs_n == 4'b1101, "R5 new select held", int'(cs_n), 13);
    keep_sel = 1'b0;
    step();
    check(cs_n == 4'hF, "R11 release on keep clear", int'(cs_n), 15);
  endtask

  // zero counts behave as one cycle
  task automatic t_zero_gaps();
    int sb;
    reset_dut(0, 0, 1'b0);
    sb = s_cnt;
    write(2);
    wait_start(sb + 1);
    write(2);
    wait_start(sb + 2);
    check(s_gap == 2, "R8 zero gap acts as one", s_gap, 2);
    write(0);
    wait_start(sb + 3);
    check(s_hi == 1'b1, "R7 change with zero gaps", int'(s_hi), 1);
    check(s_hirun == 1, "R9 zero deselect acts as one", s_hirun, 1);
  endtask

  // long between-transfer window
  task automatic t_long_gap();
    int sb;
    reset_dut(7, 1, 1'b1);
    sb = s_cnt;
    write(1);
    wait_start(sb + 1);
    write(1);
    wait_start(sb + 2);
    check(s_gap == 8, "R8 gap of 7", s_gap, 8);
    check(s_hi == 1'b0, "R6 kept across long gap", int'(s_hi), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    t_same_nokeep();
    t_change_nokeep();
    t_keep();
    t_zero_gaps();
    t_long_gap();
    repeat (5) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule